// File: doc/BRIEF.md
# Host and Microcontroller Doorbell Mailbox

This block holds two register mailboxes, one for each direction between a host processor and a display microcontroller. To send a command, the host fills a command word and three argument words, then rings a doorbell. The microcontroller is interrupted while that doorbell is set. It reads the words and acknowledges by clearing the doorbell. The return path works the same way with the roles swapped. The microcontroller writes a response word and three data words, then rings its own doorbell. The host reads the response and clears that doorbell.

Both sides use one shared address map:

| Address | Register |
|---|---|
| 0 | Forward command |
| 1 to 3 | Forward arguments |
| 4 | Forward doorbell, bit 0 |
| 8 | Return response |
| 9 to 11 | Return data |
| 12 | Return doorbell, bit 0 |

Every address can be read from either side. The read data is combinational.

A decoder watches the return registers and splits out the following:
- the echoed opcode;
- the payload length;
- the acknowledge code;
- on a refusal, the offset at which a transfer should resume.

The decoder marks a response valid only when its echo matches the opcode of the last command the host posted.

Top module: `mbox_pair`

## Requirements
- R1: After reset every register and both doorbells read 0, both interrupts are low and `rsp_valid` is 0.
- R2: While the forward doorbell is 0, a host write to address 0 to 3 lands in that forward register. From the next cycle the new value is readable on both read ports.
- R3: A host write to address 4 with bit 0 set raises the forward doorbell on the next cycle if it was 0. `mcu_irq` is high exactly while that doorbell is 1. The opcode is latched as the posted opcode at the same moment; it is bits 7:0 of the forward command register.
- R4: A microcontroller write to address 4 with bit 0 set clears a set forward doorbell on the next cycle. A write with bit 0 clear does nothing.
- R5: Host writes to addresses 0 to 3 are ignored while the forward doorbell is 1.
- R6: The microcontroller fills addresses 8 to 11 and raises the return doorbell by writing bit 0 = 1 to address 12. `host_irq` follows that doorbell. A host write of bit 0 = 1 to address 12 clears it. If a clear and a set arrive in the same cycle while the doorbell is 1, the doorbell ends at 0.
- R7: Microcontroller writes to addresses 8 to 11 are ignored while the return doorbell is 1. Writes from either side to the other side's data addresses are always ignored.
- R8: In the response word, `rsp_cmd` is bits 9:0 and `rsp_len` is bits 15:10.
- R9: `rsp_ack` is 1 when return data 1 equals 1, and `rsp_nack` is 1 when it equals 2. `rsp_resume` shows return data 2 during a NACK and 0 otherwise.
- R10: `rsp_valid` is 1 only while the return doorbell is 1 and `rsp_cmd` equals the zero-extended posted opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | 4 | Host write address |
| h_wdata | input | 32 | Host write data |
| h_raddr | input | 4 | Host read address |
| h_rdata | output | 32 | Host read data |
| m_wr | input | 1 | Microcontroller write strobe |
| m_addr | input | 4 | Microcontroller write address |
| m_wdata | input | 32 | Microcontroller write data |
| m_raddr | input | 4 | Microcontroller read address |
| m_rdata | output | 32 | Microcontroller read data |
| mcu_irq | output | 1 | Level interrupt to the microcontroller |
| host_irq | output | 1 | Level interrupt to the host |
| rsp_valid | output | 1 | Response echo matches the posted opcode |
| rsp_cmd | output | 10 | Echoed opcode |
| rsp_len | output | 6 | Payload length |
| rsp_ack | output | 1 | Acknowledge code is ACK |
| rsp_nack | output | 1 | Acknowledge code is NACK |
| rsp_resume | output | 32 | Resume offset on NACK |

## Verification
The hardest state to reach is a valid response that pairs with an earlier post. It needs three things at once:
- a forward command that has been posted and consumed;
- a return message whose echo matches that command;
- a return doorbell that is still set.

The stimulus builds that state step by step. It then changes the echo to a different opcode and checks that validity drops. Next it posts a new host command carrying that opcode and checks that validity returns. Finally it drives a clear and a set of the return doorbell in the same cycle to cover the collision case.

// File: rtl/mbox_pair.sv
module mbox_pair #(
  parameter int DW        = 32,
  parameter int EW        = 10,
  parameter int LW        = 6,
  parameter int OPW       = 8,
  parameter int ACK_CODE  = 1,
  parameter int NACK_CODE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_wr,
  input  logic [3:0]    h_addr,
  input  logic [DW-1:0] h_wdata,
  input  logic [3:0]    h_raddr,
  output logic [DW-1:0] h_rdata,
  input  logic          m_wr,
  input  logic [3:0]    m_addr,
  input  logic [DW-1:0] m_wdata,
  input  logic [3:0]    m_raddr,
  output logic [DW-1:0] m_rdata,
  output logic          mcu_irq,
  output logic          host_irq,
  output logic          rsp_valid,
  output logic [EW-1:0] rsp_cmd,
  output logic [LW-1:0] rsp_len,
  output logic          rsp_ack,
  output logic          rsp_nack,
  output logic [DW-1:0] rsp_resume
);
  localparam logic [3:0] A_FCTL = 4'd4;
  localparam logic [3:0] A_RCTL = 4'd12;

  logic [3:0][DW-1:0] fwd_q, rev_q;
  logic fwd_bell, rev_bell;
  logic [OPW-1:0] last_op;

  wire post_fwd = h_wr && h_addr == A_FCTL && h_wdata[0] && !fwd_bell;
  wire done_fwd = m_wr && m_addr == A_FCTL && m_wdata[0] && fwd_bell;
  wire post_rev = m_wr && m_addr == A_RCTL && m_wdata[0] && !rev_bell;
  wire done_rev = h_wr && h_addr == A_RCTL && h_wdata[0] && rev_bell;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_q <= '0;
      rev_q <= '0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (h_wr && !fwd_bell && h_addr == 4'(i)) fwd_q[i] <= h_wdata;
        if (m_wr && !rev_bell && m_addr == 4'(8 + i)) rev_q[i] <= m_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_bell <= 1'b0;
      rev_bell <= 1'b0;
      last_op  <= '0;
    end else begin
      if (post_fwd) begin
        fwd_bell <= 1'b1;
        last_op  <= fwd_q[0][OPW-1:0];
      end else if (done_fwd) begin
        fwd_bell <= 1'b0;
      end
      if (post_rev)      rev_bell <= 1'b1;
      else if (done_rev) rev_bell <= 1'b0;
    end
  end

  function automatic logic [DW-1:0] rd(input logic [3:0] a);
    case (a[3:2])
      2'd0:    rd = fwd_q[a[1:0]];
      2'd1:    rd = (a[1:0] == 2'd0) ? DW'(fwd_bell) : '0;
      2'd2:    rd = rev_q[a[1:0]];
      default: rd = (a[1:0] == 2'd0) ? DW'(rev_bell) : '0;
    endcase
  endfunction

  assign h_rdata    = rd(h_raddr);
  assign m_rdata    = rd(m_raddr);
  assign mcu_irq    = fwd_bell;
  assign host_irq   = rev_bell;
  assign rsp_cmd    = rev_q[0][EW-1:0];
  assign rsp_len    = rev_q[0][EW+LW-1:EW];
  assign rsp_ack    = rev_q[1] == DW'(ACK_CODE);
  assign rsp_nack   = rev_q[1] == DW'(NACK_CODE);
  assign rsp_resume = rsp_nack ? rev_q[2] : '0;
  assign rsp_valid  = rev_bell && rsp_cmd == EW'(last_op);
endmodule

// File: rtl/mbox_pair_chk.sv
module mbox_pair_chk #(parameter int DW = 32) (
  input logic               clk,
  input logic               rst_n,
  input logic               h_wr,
  input logic [3:0]         h_addr,
  input logic [DW-1:0]      h_wdata,
  input logic               m_wr,
  input logic [3:0]         m_addr,
  input logic [DW-1:0]      m_wdata,
  input logic               fwd_bell,
  input logic               rev_bell,
  input logic [3:0][DW-1:0] fwd_q,
  input logic [3:0][DW-1:0] rev_q,
  input logic               rsp_valid,
  input logic               host_irq
);
  // R3
  post_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == 4'd4 && h_wdata[0] && !fwd_bell) |=> fwd_bell);
  // R4
  consume_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wr && m_addr == 4'd4 && m_wdata[0] && fwd_bell) |=> !fwd_bell);
  // R5
  fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_bell |=> $stable(fwd_q));
  // R7
  rev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rev_bell |=> $stable(rev_q));
  // R6
  rev_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == 4'd12 && h_wdata[0] && rev_bell) |=> !rev_bell);
  // R10
  valid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> host_irq);
endmodule

bind mbox_pair mbox_pair_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
  .m_wr(m_wr), .m_addr(m_addr), .m_wdata(m_wdata), .fwd_bell(fwd_bell),
  .rev_bell(rev_bell), .fwd_q(fwd_q), .rev_q(rev_q), .rsp_valid(rsp_valid),
  .host_irq(host_irq)
);

// File: tb/sim_mbox_pair.sv
`timescale 1ns/1ps
module sim_mbox_pair;
  logic clk = 0, rst_n = 0;
  logic h_wr = 0, m_wr = 0;
  logic [3:0] h_addr = 0, m_addr = 0, h_raddr = 0, m_raddr = 0;
  logic [31:0] h_wdata = 0, m_wdata = 0, h_rdata, m_rdata, rsp_resume;
  logic mcu_irq, host_irq, rsp_valid, rsp_ack, rsp_nack;
  logic [9:0] rsp_cmd;
  logic [5:0] rsp_len;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  mbox_pair u0 (.*);

  // op: 0 host write, 1 mcu write, 2 host read check; then req, addr, data, expected
  localparam int NV = 26;
  localparam logic [73:0] VEC [NV] = '{
    {2'd0, 4'd2,  4'd0,  32'h000000A0, 32'h0},
    {2'd0, 4'd2,  4'd1,  32'h00100080, 32'h0},
    {2'd0, 4'd2,  4'd2,  32'h11223344, 32'h0},
    {2'd0, 4'd2,  4'd3,  32'h55667788, 32'h0},
    {2'd2, 4'd2,  4'd0,  32'h0, 32'h000000A0},   // R2
    {2'd2, 4'd2,  4'd1,  32'h0, 32'h00100080},   // R2
    {2'd2, 4'd2,  4'd3,  32'h0, 32'h55667788},   // R2
    {2'd0, 4'd3,  4'd4,  32'h00000001, 32'h0},
    {2'd2, 4'd3,  4'd4,  32'h0, 32'h00000001},   // R3
    {2'd0, 4'd5,  4'd0,  32'hDEAD0021, 32'h0},
    {2'd0, 4'd5,  4'd1,  32'hFFFFFFFF, 32'h0},
    {2'd2, 4'd5,  4'd0,  32'h0, 32'h000000A0},   // R5
    {2'd2, 4'd5,  4'd1,  32'h0, 32'h00100080},   // R5
    {2'd1, 4'd4,  4'd4,  32'h00000000, 32'h0},
    {2'd2, 4'd4,  4'd4,  32'h0, 32'h00000001},   // R4
    {2'd1, 4'd4,  4'd4,  32'h00000001, 32'h0},
    {2'd2, 4'd4,  4'd4,  32'h0, 32'h00000000},   // R4
    {2'd0, 4'd7,  4'd8,  32'h12345678, 32'h0},
    {2'd2, 4'd7,  4'd8,  32'h0, 32'h00000000},   // R7
    {2'd1, 4'd6,  4'd8,  32'h000030A0, 32'h0},
    {2'd1, 4'd6,  4'd9,  32'h00000002, 32'h0},
    {2'd1, 4'd6,  4'd10, 32'h00000040, 32'h0},
    {2'd1, 4'd6,  4'd12, 32'h00000001, 32'h0},
    {2'd2, 4'd6,  4'd12, 32'h0, 32'h00000001},   // R6
    {2'd1, 4'd7,  4'd9,  32'h00000001, 32'h0},
    {2'd2, 4'd7,  4'd9,  32'h0, 32'h00000002}    // R7
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); h_wr = 1; h_addr = a; h_wdata = d;
    @(negedge clk); h_wr = 0;
  endtask

  task automatic mw(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); m_wr = 1; m_addr = a; m_wdata = d;
    @(negedge clk); m_wr = 0;
  endtask

  task automatic hrd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); h_raddr = a; #1 d = h_rdata;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    hrd(4'd0, r);  chk("R1", r, 0);
    hrd(4'd4, r);  chk("R1", r, 0);
    hrd(4'd12, r); chk("R1", r, 0);
    #1 chk("R1", {29'd0, mcu_irq, host_irq, rsp_valid}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [73:0] v;
      v = VEC[i];
      case (v[73:72])
        2'd0: hw(v[67:64], v[63:32]);
        2'd1: mw(v[67:64], v[63:32]);
        default: begin
          hrd(v[67:64], r);
          if (v[71:68] == 4'd2) chk("R2", r, v[31:0]);
          else if (v[71:68] == 4'd3) chk("R3", r, v[31:0]);
          else if (v[71:68] == 4'd4) chk("R4", r, v[31:0]);
          else if (v[71:68] == 4'd5) chk("R5", r, v[31:0]);
          else if (v[71:68] == 4'd6) chk("R6", r, v[31:0]);
          else chk("R7", r, v[31:0]);
        end
      endcase
    end

    @(negedge clk); m_raddr = 4'd1; #1;
    chk("R2", m_rdata, 32'h00100080);
    chk("R6", {30'd0, host_irq, mcu_irq}, 32'h2);
    chk("R8", {22'd0, rsp_cmd}, 32'h0A0);
    chk("R8", {26'd0, rsp_len}, 32'd12);
    chk("R9", {30'd0, rsp_ack, rsp_nack}, 32'h1);
    chk("R9", rsp_resume, 32'h40);
    chk("R10", {31'd0, rsp_valid}, 1);

    hw(4'd12, 1); #1;   // host takes response
    chk("R6", {31'd0, host_irq}, 0);
    chk("R10", {31'd0, rsp_valid}, 0);

    mw(4'd9, 1); #1;
    chk("R9", {30'd0, rsp_ack, rsp_nack}, 32'h2);
    chk("R9", rsp_resume, 0);

    mw(4'd8, 32'h00000021);
    mw(4'd12, 1); #1;
    chk("R10", {31'd0, rsp_valid}, 0);   // echo 0x21 vs posted 0xA0

    hw(4'd0, 32'h00000021);
    hw(4'd4, 1); #1;
    chk("R3", {31'd0, mcu_irq}, 1);
    chk("R10", {31'd0, rsp_valid}, 1);

    // R6 same-cycle clear and set of return doorbell while set
    @(negedge clk);
    h_wr = 1; h_addr = 4'd12; h_wdata = 1;
    m_wr = 1; m_addr = 4'd12; m_wdata = 1;
    @(negedge clk); h_wr = 0; m_wr = 0;
    hrd(4'd12, r); chk("R6", r, 0);

    // R7 MCU cannot touch forward registers
    mw(4'd0, 32'hFFFFFFFF);
    hrd(4'd0, r); chk("R7", r, 32'h21);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule